// File: doc/BRIEF.md
# Configurable Interrupt Trigger Detector

This block turns a bank of raw interrupt lines into a vector of pending bits for an interrupt controller that follows it. Every line carries its own three configuration bits: a sense bit, a polarity bit and a dual-edge bit. Together they make that line one of five kinds: level-high, level-low, rising edge, falling edge or both edges. The lines are sampled once per clock. The block keeps the previous sample of every line and compares each new sample against it.

Level lines report their active condition directly. Edge lines latch a pending bit when the selected edge is seen. That bit then holds until software, through the controller in front of it, presents a clear mask. The clear mask acts only on edge lines. If a new edge arrives in the same cycle as a clear, the edge wins.

Top module: `irq_trig_detect`

## Requirements
- R1: The block handles NUM_LINES lines (default 51, numbered 0 to 50). Bit i of every vector port belongs to line i.
- R2: A line with cfg_sense_i=1 and cfg_pol_i=1 is level-high. After each rising clock edge, pending_o for that line equals the line value sampled at that edge.
- R3: A line with cfg_sense_i=1 and cfg_pol_i=0 is level-low. After each rising clock edge, pending_o for that line equals the inverse of the line value sampled at that edge.
- R4: A line with cfg_sense_i=0 and cfg_dual_i=1 sets its pending bit whenever the new sample differs from the stored previous sample.
- R5: A line with cfg_sense_i=0, cfg_dual_i=0 and cfg_pol_i=1 sets its pending bit when the previous sample is 0 and the new sample is 1.
- R6: A line with cfg_sense_i=0, cfg_dual_i=0 and cfg_pol_i=0 sets its pending bit when the previous sample is 1 and the new sample is 0.
- R7: A pending bit on an edge line stays set across cycles with no detected edge for as long as its edge_clr_i bit is 0.
- R8: A 1 in edge_clr_i on an edge line with no edge in that cycle makes its pending bit 0 after the clock edge.
- R9: A 1 in edge_clr_i on a level line has no effect; the pending bit still follows R2 or R3.
- R10: When an edge is detected and edge_clr_i is 1 for the same line in the same cycle, the pending bit is 1 afterwards.
- R11: While rst_n is low, pending_o is all zero and every stored previous sample is 0. As a result, a 1 on a rising or dual-edge line in the first cycle after reset counts as an edge.
- R12: The stored previous sample of every line is updated on every clock, whatever that line's configuration. A line held at 1 in level mode and then switched to rising-edge mode therefore shows no edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_i | input | NUM_LINES | Raw interrupt lines, already synchronised |
| cfg_sense_i | input | NUM_LINES | 1 = level-sensitive, 0 = edge-sensitive |
| cfg_pol_i | input | NUM_LINES | Level: 1 = active-high. Edge without dual: 1 = rising, 0 = falling |
| cfg_dual_i | input | NUM_LINES | On edge lines, 1 = detect both edges |
| edge_clr_i | input | NUM_LINES | Clear mask for pending bits of edge lines |
| pending_o | output | NUM_LINES | Raw pending vector |

## Verification
The bench goes after the collision of a clear and a fresh edge in the same cycle. A design that lets the clear win would drop an interrupt there. It checks that a clear mask aimed at level lines leaves them untouched; a design that masked them would hide an asserted level. It resets with lines held high, to show that an edge seen against a zero previous sample fires; a design that loaded the first sample into the previous-sample register would miss it. It also switches lines from level to edge mode, to show that the previous sample was tracked all along; a design that froze it in level mode would report a phantom edge. Long random runs mix all five modes, so that a swapped polarity or a wrong dual-edge decode shows up against the bench's own model.

// File: rtl/trig_pkg.sv
package trig_pkg;

  typedef enum logic [2:0] {
    MODE_LVL_HIGH = 3'd0,
    MODE_LVL_LOW  = 3'd1,
    MODE_RISE     = 3'd2,
    MODE_FALL     = 3'd3,
    MODE_BOTH     = 3'd4
  } trig_mode_e;

  // Sense bit dominates; dual-edge only matters for edge lines.
  function automatic trig_mode_e decode_mode(input logic sense, input logic pol,
                                             input logic dual);
    if (sense)     return pol ? MODE_LVL_HIGH : MODE_LVL_LOW;
    else if (dual) return MODE_BOTH;
    else           return pol ? MODE_RISE : MODE_FALL;
  endfunction

endpackage

// File: rtl/trig_sample_reg.sv
module trig_sample_reg #(
  parameter int NUM_LINES = 51
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] line_i,
  output logic [NUM_LINES-1:0] prev_o
);

  logic [NUM_LINES-1:0] prev_d, prev_q;
  logic                 seen_q;

  always_comb begin
    prev_d = line_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      seen_q <= 1'b0;
    end else begin
      prev_q <= prev_d;
      seen_q <= 1'b1;
    end
  end

  assign prev_o = prev_q;

  // R12: previous sample always tracks the line, whatever the mode
  p_prev_tracks_r12: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q |-> (prev_q == $past(line_i)));

endmodule

// File: rtl/trig_line_eval.sv
module trig_line_eval #(
  parameter int NUM_LINES = 51
) (
  input  logic [NUM_LINES-1:0] line_i,
  input  logic [NUM_LINES-1:0] prev_i,
  input  logic [NUM_LINES-1:0] sense_i,
  input  logic [NUM_LINES-1:0] pol_i,
  input  logic [NUM_LINES-1:0] dual_i,
  output logic [NUM_LINES-1:0] level_act_o,
  output logic [NUM_LINES-1:0] edge_hit_o,
  output logic [NUM_LINES-1:0] edge_mode_o
);
  import trig_pkg::*;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    trig_mode_e mode;
    logic       rise, fall;

    always_comb begin
      mode           = decode_mode(sense_i[g], pol_i[g], dual_i[g]);
      rise           = ~prev_i[g] & line_i[g];
      fall           = prev_i[g] & ~line_i[g];
      level_act_o[g] = 1'b0;
      edge_hit_o[g]  = 1'b0;
      edge_mode_o[g] = 1'b1;
      case (mode)
        MODE_LVL_HIGH: begin level_act_o[g] = line_i[g];  edge_mode_o[g] = 1'b0; end
        MODE_LVL_LOW:  begin level_act_o[g] = ~line_i[g]; edge_mode_o[g] = 1'b0; end
        MODE_RISE:     edge_hit_o[g] = rise;
        MODE_FALL:     edge_hit_o[g] = fall;
        MODE_BOTH:     edge_hit_o[g] = rise | fall;
        default:       edge_hit_o[g] = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/trig_pend_reg.sv
module trig_pend_reg #(
  parameter int NUM_LINES = 51
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] level_act_i,
  input  logic [NUM_LINES-1:0] edge_hit_i,
  input  logic [NUM_LINES-1:0] edge_mode_i,
  input  logic [NUM_LINES-1:0] clr_i,
  output logic [NUM_LINES-1:0] pend_o
);

  logic [NUM_LINES-1:0] pend_d, pend_q;
  logic                 seen_q;

  always_comb begin
    for (int i = 0; i < NUM_LINES; i++) begin
      if (edge_mode_i[i]) pend_d[i] = edge_hit_i[i] | (pend_q[i] & ~clr_i[i]);
      else                pend_d[i] = level_act_i[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      seen_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
      seen_q <= 1'b1;
    end
  end

  assign pend_o = pend_q;

  // R7: uncleared edge pending never drops
  p_edge_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q |-> (($past(edge_mode_i & pend_q & ~clr_i) & ~pend_q) == '0));

  // R8: cleared edge pending with no new edge drops
  p_edge_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q |-> ((pend_q & $past(edge_mode_i & clr_i & ~edge_hit_i)) == '0));

  // R10: a detected edge always lands, clear or not
  p_edge_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q |-> ((pend_q & $past(edge_mode_i & edge_hit_i)) ==
                $past(edge_mode_i & edge_hit_i)));

endmodule

// File: rtl/irq_trig_detect.sv
module irq_trig_detect #(
  parameter int NUM_LINES = 51
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] line_i,
  input  logic [NUM_LINES-1:0] cfg_sense_i,
  input  logic [NUM_LINES-1:0] cfg_pol_i,
  input  logic [NUM_LINES-1:0] cfg_dual_i,
  input  logic [NUM_LINES-1:0] edge_clr_i,
  output logic [NUM_LINES-1:0] pending_o
);

  logic [NUM_LINES-1:0] prev_w, level_act_w, edge_hit_w, edge_mode_w;
  logic                 seen_q;

  trig_sample_reg #(.NUM_LINES(NUM_LINES)) u_sample (
    .clk(clk), .rst_n(rst_n), .line_i(line_i), .prev_o(prev_w)
  );

  trig_line_eval #(.NUM_LINES(NUM_LINES)) u_eval (
    .line_i(line_i), .prev_i(prev_w), .sense_i(cfg_sense_i),
    .pol_i(cfg_pol_i), .dual_i(cfg_dual_i),
    .level_act_o(level_act_w), .edge_hit_o(edge_hit_w),
    .edge_mode_o(edge_mode_w)
  );

  trig_pend_reg #(.NUM_LINES(NUM_LINES)) u_pend (
    .clk(clk), .rst_n(rst_n), .level_act_i(level_act_w),
    .edge_hit_i(edge_hit_w), .edge_mode_i(edge_mode_w),
    .clr_i(edge_clr_i), .pend_o(pending_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= 1'b0;
    else        seen_q <= 1'b1;
  end

  // R2, R3, R9: level lines mirror the polarity-adjusted sample, clear ignored
  p_level_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q |-> ((pending_o & $past(cfg_sense_i)) ==
                ($past(cfg_sense_i) & ~($past(cfg_pol_i) ^ $past(line_i)))));

  // R4: any change on a dual-edge line sets pending
  p_dual_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q |-> ((pending_o & $past(~cfg_sense_i & cfg_dual_i & (line_i ^ prev_w))) ==
                $past(~cfg_sense_i & cfg_dual_i & (line_i ^ prev_w))));

  // R11: reset state
  p_reset_clear_r11: assert property (@(posedge clk)
    !rst_n |-> (pending_o == '0));

endmodule

// File: tb/sim_irq_trig_detect.sv
module sim_irq_trig_detect;
  localparam int N = 51;
  typedef logic [N-1:0] vec_t;

  logic clk = 1'b0;
  logic rst_n;
  vec_t line, sense, pol, dual, clr, pend;
  vec_t m_prev, m_pend;
  int   errors = 0;
  int   checks = 0;
  bit   done = 1'b0;

  always #4 clk = ~clk;

  irq_trig_detect #(.NUM_LINES(N)) u0 (
    .clk(clk), .rst_n(rst_n), .line_i(line), .cfg_sense_i(sense),
    .cfg_pol_i(pol), .cfg_dual_i(dual), .edge_clr_i(clr), .pending_o(pend)
  );

  function automatic vec_t ref_next(vec_t l, vec_t p, vec_t q, vec_t s,
                                    vec_t e, vec_t d, vec_t c);
    vec_t r;
    for (int i = 0; i < N; i++) begin
      logic hit;
      if (s[i]) r[i] = e[i] ? l[i] : ~l[i];
      else begin
        if (d[i])      hit = (l[i] != p[i]);
        else if (e[i]) hit = ~p[i] & l[i];
        else           hit = p[i] & ~l[i];
        r[i] = hit | (q[i] & ~c[i]);
      end
    end
    return r;
  endfunction

  function automatic vec_t rnd();
    return vec_t'({$urandom, $urandom});
  endfunction

  task automatic check(string tag, vec_t exp);
    checks++;
    if (pend !== exp) begin
      errors++;
      $display("FAIL %s: pending=%h expected=%h", tag, pend, exp);
    end
  endtask

  task automatic step(vec_t l, vec_t s, vec_t e, vec_t d, vec_t c, string tag);
    line = l; sense = s; pol = e; dual = d; clr = c;
    @(posedge clk);
    m_pend = ref_next(l, m_prev, m_pend, s, e, d, c);
    m_prev = l;
    @(negedge clk);
    check(tag, m_pend);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    m_prev = '0; m_pend = '0;
    repeat (2) @(negedge clk);
    check("R11 reset", '0);
    rst_n = 1'b1;
  endtask

  localparam vec_t ONES = '1;
  localparam vec_t ZERO = '0;

  initial begin
    vec_t a;
    void'($urandom(32'h5eed_1234));
    line = '0; sense = '0; pol = '0; dual = '0; clr = '0;
    do_reset();
    a = rnd();
    // R2 level-high
    step(a, ONES, ONES, ZERO, ZERO, "R2");
    if (pend !== a) begin errors++; $display("FAIL R2: pending=%h expected=%h", pend, a); end
    checks++;
    // R3 level-low
    step(a, ONES, ZERO, rnd(), ZERO, "R3");
    // R9 clear on level lines ignored
    step(a, ONES, ONES, ZERO, ONES, "R9");
    if (pend !== a) begin errors++; $display("FAIL R9: pending=%h expected=%h", pend, a); end
    checks++;
    // R5 rising: 0 -> 1 (clear first to empty pending)
    step(ZERO, ZERO, ONES, ZERO, ONES, "R8");
    step(ONES, ZERO, ONES, ZERO, ZERO, "R5");
    step(ONES, ZERO, ONES, ZERO, ZERO, "R7");
    step(ZERO, ZERO, ONES, ZERO, ZERO, "R7 falling ignored by rising");
    step(ZERO, ZERO, ONES, ZERO, ONES, "R8");
    // R6 falling
    step(ONES, ZERO, ZERO, ZERO, ZERO, "R6 no edge on rise");
    step(ZERO, ZERO, ZERO, ZERO, ZERO, "R6");
    step(ZERO, ZERO, ZERO, ZERO, ONES, "R8");
    // R4 dual
    step(a, ZERO, rnd(), ONES, ZERO, "R4");
    step(~a, ZERO, rnd(), ONES, ONES, "R10");
    step(~a, ZERO, rnd(), ONES, ONES, "R8");
    // R10 edge with clear in the same cycle on rising lines
    step(ZERO, ZERO, ONES, ZERO, ONES, "R8");
    step(ONES, ZERO, ONES, ZERO, ONES, "R10");
    if (pend !== ONES) begin errors++; $display("FAIL R10: pending=%h expected=%h", pend, ONES); end
    checks++;
    // R12 previous sample tracked in level mode
    step(ONES, ONES, ONES, ZERO, ZERO, "R12 level");
    step(ONES, ZERO, ONES, ZERO, ONES, "R12");
    if (pend !== ZERO) begin errors++; $display("FAIL R12: pending=%h expected=%h", pend, ZERO); end
    checks++;
    // R11 reset with lines high: first sample is an edge
    line = ONES; sense = ZERO; pol = ONES; dual = ZERO; clr = ZERO;
    @(negedge clk);
    do_reset();
    step(ONES, ZERO, ONES, ZERO, ZERO, "R11 first edge");
    if (pend !== ONES) begin errors++; $display("FAIL R11: pending=%h expected=%h", pend, ONES); end
    checks++;
    // R1 random mix of all modes
    for (int k = 0; k < 3000; k++) begin
      vec_t c;
      c = ((k % 4) == 0) ? rnd() : (rnd() & rnd() & rnd());
      step(rnd(), rnd(), rnd(), rnd(), c, "R1 random");
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: pending=%h expected=completion", pend);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule